// File: doc/BRIEF.md
# Stack Push Execution Unit

This unit carries out one stack push for a processor core. A request on `start_i` carries the current stack pointer, the stack address width, the operand width, the kind of source (general register, memory data, immediate, segment selector, or the stack pointer itself), the source value, and the context needed for fault checks: LOCK prefix, processor mode and stack segment limit. The unit captures the request, fetches a memory source when one is needed, then either commits the push or reports a fault. A commit is one store request (address, data, byte enables) plus the updated stack pointer.

The control is a state machine with six states. ST_IDLE waits for `start_i`. It takes the transition *launch_read* to ST_READ for a memory source, or *launch_exec* to ST_EXEC for any other source. ST_READ issues the source read and takes *read_done* to ST_EXEC. ST_EXEC commits or faults in one cycle and then takes *finish* back to ST_IDLE. The exception is a real-mode pointer of 1, which takes *escalate* to ST_ESC_DF. ST_ESC_DF takes *double_fault* to ST_ESC_SHUT, which takes *shut_down* to ST_HALT. ST_HALT is left only by reset.

Top module: `stack_push_unit`

## Requirements
- R1: A push without fault lowers the stack pointer by 2, 4 or 8 for operand size code 0 (16 bit), 1 (32 bit) or 2 (64 bit). The store goes to the new pointer, and `sp_o` shows the new pointer in the cycle where `done_o` is high.
- R2: Stack size code 0 updates only pointer bits [15:0] and code 1 only bits [31:0]. The updated bits wrap, and the higher bits keep their value. Code 2 updates all 64 bits.
- R3: An immediate source (kind 2) is sign-extended from 8, 16 or 32 bits (imm width code 0, 1 or 2) and then cut to the operand size.
- R4: A segment source (kind 3) stores the low 16 bits of the source value, zero-extended. With a 64-bit operand all 8 byte enables are set. With a 32-bit operand only byte enables 0x03 are set, and the pointer still drops by 4.
- R5: A push of the pointer itself (kind 4) stores the old pointer value. With parameter `LEGACY_NEW_SP`=1 it stores the decremented value instead.
- R6: A memory source (kind 1) reads at base plus `mem_disp_i`, in the cycle after start. The base is the old pointer when `mem_sp_base_i`=1 and `src_val_i` otherwise. The data read is what gets stored.
- R7: A request with `lock_i`=1 ends with fault code 2 (invalid opcode), no store, and `sp_o` equal to the old pointer.
- R8: A segment source with `seg_legacy_i`=1 in mode code 2 (64-bit) ends with fault code 2. In other modes it is pushed normally.
- R9: When the new pointer, masked to the stack size, is above `stk_limit_i`, the request ends with fault code 1 (stack fault). There is no store and the pointer is unchanged. A pointer equal to the limit is accepted.
- R10: In mode code 0 (real) with a masked old pointer of 1, the unit reports fault code 1 with `done_o` low. In the next cycle it reports code 3 (double fault). In the cycle after that it reports code 4 (shutdown) with `done_o` high. From then on `shutdown_o` stays high, and new requests are ignored until reset.
- R11: `done_o` is high for exactly one cycle. This is the cycle after start for non-memory sources, and the second cycle after start for memory sources. The LOCK fault is checked before the 64-bit segment fault, which is checked before the real-mode escalation, which is checked before the limit fault.
- R12: After reset `done_o`, `wr_en_o`, `rd_en_o` and `shutdown_o` are low and `fault_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Request strobe, accepted in ST_IDLE |
| sp_i | input | 64 | Current stack pointer |
| stk_size_i | input | 2 | Stack size code: 0=16, 1=32, 2=64 |
| op_size_i | input | 2 | Operand size code: 0=16, 1=32, 2=64 |
| src_kind_i | input | 3 | 0 register, 1 memory, 2 immediate, 3 segment, 4 stack pointer |
| src_val_i | input | 64 | Source value, or the memory base address |
| imm_width_i | input | 2 | Immediate width code: 0=8, 1=16, 2=32 |
| seg_legacy_i | input | 1 | Segment is one of the four legacy segments |
| mem_sp_base_i | input | 1 | Memory operand address is based on the stack pointer |
| mem_disp_i | input | 64 | Memory operand displacement |
| lock_i | input | 1 | LOCK prefix present |
| mode_i | input | 2 | Mode: 0 real, 1 protected, 2 64-bit |
| stk_limit_i | input | 64 | Stack segment limit |
| rd_en_o | output | 1 | Source read request |
| rd_addr_o | output | 64 | Source read address |
| rd_data_i | input | 64 | Source read data, same cycle |
| wr_en_o | output | 1 | Store request |
| wr_addr_o | output | 64 | Store address |
| wr_data_o | output | 64 | Store data |
| wr_be_o | output | 8 | Store byte enables |
| sp_o | output | 64 | Resulting stack pointer, valid with done_o |
| done_o | output | 1 | End of request |
| fault_o | output | 3 | 0 none, 1 stack, 2 invalid opcode, 3 double, 4 shutdown |
| shutdown_o | output | 1 | Sticky shutdown |

## Verification
The hardest situation to reach from the ports is the escalation chain. It needs real mode and a masked pointer of exactly 1, and random stimulus almost never produces that; the random generator even steers away from it so that ordinary pushes stay predictable. A directed sequence therefore starts a push with a 16-bit stack and a pointer of 1. It follows the fault code through each cycle, then issues further requests to show that the halted unit ignores them, and resets to recover. A second hard case is a limit that sits exactly on the new pointer. Directed pushes place the limit one below the new pointer and exactly on it.

// File: rtl/push_pkg.sv
package push_pkg;
    localparam int XLEN  = 64;
    localparam int NBYTE = XLEN / 8;

    typedef enum logic [2:0] {
        K_REG  = 3'd0,
        K_MEM  = 3'd1,
        K_IMM  = 3'd2,
        K_SEG  = 3'd3,
        K_SELF = 3'd4
    } src_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_STACK    = 3'd1,
        FLT_UNDEF    = 3'd2,
        FLT_DOUBLE   = 3'd3,
        FLT_SHUTDOWN = 3'd4
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_EXEC, ST_ESC_DF, ST_ESC_SHUT, ST_HALT
    } state_e;

    typedef struct packed {
        logic [XLEN-1:0] sp;
        logic [1:0]      stk;
        logic [1:0]      op;
        logic [2:0]      kind;
        logic [XLEN-1:0] val;
        logic [1:0]      immw;
        logic            seg_legacy;
        logic            sp_base;
        logic [XLEN-1:0] disp;
        logic            lock;
        logic [1:0]      mode;
        logic [XLEN-1:0] limit;
    } req_t;
endpackage

// File: rtl/push_sp_calc.sv
module push_sp_calc
    import push_pkg::*;
(
    input  logic [XLEN-1:0] sp_old,
    input  logic [1:0]      stk,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] limit,
    output logic [XLEN-1:0] sp_new,
    output logic            over_limit,
    output logic            old_is_one
);
    logic [XLEN-1:0] step, diff, new_m, old_m;

    always_comb begin
        unique case (op)
            2'd0:    step = XLEN'(2);
            2'd1:    step = XLEN'(4);
            default: step = XLEN'(8);
        endcase
        diff = sp_old - step;
        unique case (stk)
            2'd0: begin
                sp_new = {sp_old[XLEN-1:16], diff[15:0]};
                new_m  = {{(XLEN-16){1'b0}}, diff[15:0]};
                old_m  = {{(XLEN-16){1'b0}}, sp_old[15:0]};
            end
            2'd1: begin
                sp_new = {sp_old[XLEN-1:32], diff[31:0]};
                new_m  = {{(XLEN-32){1'b0}}, diff[31:0]};
                old_m  = {{(XLEN-32){1'b0}}, sp_old[31:0]};
            end
            default: begin
                sp_new = diff;
                new_m  = diff;
                old_m  = sp_old;
            end
        endcase
        over_limit = new_m > limit;
        old_is_one = old_m == XLEN'(1);
    end
endmodule

// File: rtl/push_data_fmt.sv
module push_data_fmt
    import push_pkg::*;
#(
    parameter bit LEGACY_NEW_SP = 1'b0
) (
    input  logic [2:0]       kind,
    input  logic [1:0]       op,
    input  logic [1:0]       immw,
    input  logic [XLEN-1:0]  val,
    input  logic [XLEN-1:0]  mem_data,
    input  logic [XLEN-1:0]  sp_old,
    input  logic [XLEN-1:0]  sp_new,
    output logic [XLEN-1:0]  data,
    output logic [NBYTE-1:0] be
);
    logic [XLEN-1:0] raw, imm_x, self_v;

    generate
        if (LEGACY_NEW_SP) begin : g_self_new
            assign self_v = sp_new;
        end else begin : g_self_old
            assign self_v = sp_old;
        end
    endgenerate

    always_comb begin
        unique case (immw)
            2'd0:    imm_x = {{(XLEN-8){val[7]}}, val[7:0]};
            2'd1:    imm_x = {{(XLEN-16){val[15]}}, val[15:0]};
            default: imm_x = {{(XLEN-32){val[31]}}, val[31:0]};
        endcase
        unique case (kind)
            K_MEM:   raw = mem_data;
            K_IMM:   raw = imm_x;
            K_SEG:   raw = {{(XLEN-16){1'b0}}, val[15:0]};
            K_SELF:  raw = self_v;
            default: raw = val;
        endcase
        unique case (op)
            2'd0: begin
                data = {{(XLEN-16){1'b0}}, raw[15:0]};
                be   = NBYTE'(8'h03);
            end
            2'd1: begin
                data = {{(XLEN-32){1'b0}}, raw[31:0]};
                be   = (kind == K_SEG) ? NBYTE'(8'h03) : NBYTE'(8'h0F);
            end
            default: begin
                data = raw;
                be   = '1;
            end
        endcase
    end
endmodule

// File: rtl/push_fsm.sv
module push_fsm
    import push_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_mem,
    input  logic   undef_flt,
    input  logic   real_one,
    input  logic   limit_flt,
    output state_e state,
    output logic   load_req,
    output logic   rd_en,
    output logic   wr_en,
    output logic   done,
    output fault_e fault,
    output logic   shutdown
);
    state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = start_mem ? ST_READ : ST_EXEC;
            ST_READ:     nxt = ST_EXEC;
            ST_EXEC:     nxt = (!undef_flt && real_one) ? ST_ESC_DF : ST_IDLE;
            ST_ESC_DF:   nxt = ST_ESC_SHUT;
            ST_ESC_SHUT: nxt = ST_HALT;
            default:     nxt = ST_HALT;
        endcase
    end

    always_comb begin
        load_req = 1'b0;
        rd_en    = 1'b0;
        wr_en    = 1'b0;
        done     = 1'b0;
        fault    = FLT_NONE;
        shutdown = 1'b0;
        unique case (state)
            ST_IDLE: load_req = start;
            ST_READ: rd_en = 1'b1;
            ST_EXEC: begin
                if (undef_flt) begin
                    fault = FLT_UNDEF;
                    done  = 1'b1;
                end else if (real_one) begin
                    fault = FLT_STACK;
                end else if (limit_flt) begin
                    fault = FLT_STACK;
                    done  = 1'b1;
                end else begin
                    wr_en = 1'b1;
                    done  = 1'b1;
                end
            end
            ST_ESC_DF:   fault = FLT_DOUBLE;
            ST_ESC_SHUT: begin
                fault = FLT_SHUTDOWN;
                done  = 1'b1;
            end
            default: shutdown = 1'b1;
        endcase
    end

    // R11: done lasts one cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: double fault is followed by the shutdown report
    p_escalate_shut_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault == FLT_DOUBLE) |=> (fault == FLT_SHUTDOWN && done));
    // R10: shutdown never drops before reset
    p_shutdown_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> shutdown);
endmodule

// File: rtl/stack_push_unit.sv
module stack_push_unit
    import push_pkg::*;
#(
    parameter bit LEGACY_NEW_SP = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [63:0] sp_i,
    input  logic [1:0]  stk_size_i,
    input  logic [1:0]  op_size_i,
    input  logic [2:0]  src_kind_i,
    input  logic [63:0] src_val_i,
    input  logic [1:0]  imm_width_i,
    input  logic        seg_legacy_i,
    input  logic        mem_sp_base_i,
    input  logic [63:0] mem_disp_i,
    input  logic        lock_i,
    input  logic [1:0]  mode_i,
    input  logic [63:0] stk_limit_i,
    output logic        rd_en_o,
    output logic [63:0] rd_addr_o,
    input  logic [63:0] rd_data_i,
    output logic        wr_en_o,
    output logic [63:0] wr_addr_o,
    output logic [63:0] wr_data_o,
    output logic [7:0]  wr_be_o,
    output logic [63:0] sp_o,
    output logic        done_o,
    output logic [2:0]  fault_o,
    output logic        shutdown_o
);
    req_t            req;
    logic [XLEN-1:0] mem_q, sp_new, data;
    logic [NBYTE-1:0] be;
    logic            load_req, over_limit, old_is_one, undef_flt, real_one;
    state_e          state;
    fault_e          fault;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req   <= '0;
            mem_q <= '0;
        end else begin
            if (load_req) begin
                req.sp         <= sp_i;
                req.stk        <= stk_size_i;
                req.op         <= op_size_i;
                req.kind       <= src_kind_i;
                req.val        <= src_val_i;
                req.immw       <= imm_width_i;
                req.seg_legacy <= seg_legacy_i;
                req.sp_base    <= mem_sp_base_i;
                req.disp       <= mem_disp_i;
                req.lock       <= lock_i;
                req.mode       <= mode_i;
                req.limit      <= stk_limit_i;
            end
            if (rd_en_o) mem_q <= rd_data_i;
        end
    end

    push_sp_calc u_sp (
        .sp_old(req.sp), .stk(req.stk), .op(req.op), .limit(req.limit),
        .sp_new(sp_new), .over_limit(over_limit), .old_is_one(old_is_one)
    );

    push_data_fmt #(.LEGACY_NEW_SP(LEGACY_NEW_SP)) u_fmt (
        .kind(req.kind), .op(req.op), .immw(req.immw), .val(req.val),
        .mem_data(mem_q), .sp_old(req.sp), .sp_new(sp_new),
        .data(data), .be(be)
    );

    assign undef_flt = req.lock ||
                       (req.kind == K_SEG && req.seg_legacy && req.mode == 2'd2);
    assign real_one  = (req.mode == 2'd0) && old_is_one;

    push_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start_i),
        .start_mem(src_kind_i == K_MEM),
        .undef_flt(undef_flt), .real_one(real_one), .limit_flt(over_limit),
        .state(state), .load_req(load_req), .rd_en(rd_en_o), .wr_en(wr_en_o),
        .done(done_o), .fault(fault), .shutdown(shutdown_o)
    );

    assign fault_o   = fault;
    assign rd_addr_o = rd_en_o ? ((req.sp_base ? req.sp : req.val) + req.disp) : '0;
    assign wr_addr_o = wr_en_o ? sp_new : '0;
    assign wr_data_o = wr_en_o ? data : '0;
    assign wr_be_o   = wr_en_o ? be : '0;
    assign sp_o      = wr_en_o ? sp_new : req.sp;

    // R1: a store lands on the reported pointer, which moved
    p_store_at_sp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o == sp_o && sp_o != req.sp && wr_be_o != '0));
    // R9: a faulting end leaves the pointer alone
    p_fault_keeps_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o != 3'd0) |-> (sp_o == req.sp && !wr_en_o));
    // R6: a source read is followed by the execute cycle
    p_read_then_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> (state == ST_EXEC && !rd_en_o));
endmodule

// File: tb/test_stack_push_unit.sv
module test_stack_push_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
    logic [63:0] sp_i = '0, src_val_i = '0, mem_disp_i = '0, stk_limit_i = '1;
    logic [1:0]  stk_size_i = '0, op_size_i = '0, imm_width_i = '0, mode_i = 2'd1;
    logic [2:0]  src_kind_i = '0;
    logic        seg_legacy_i = 1'b0, mem_sp_base_i = 1'b0, lock_i = 1'b0;
    logic        rd_en_o, wr_en_o, done_o, shutdown_o;
    logic [63:0] rd_addr_o, rd_data_i, wr_addr_o, wr_data_o, sp_o;
    logic [7:0]  wr_be_o;
    logic [2:0]  fault_o;

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: content derived from the address
    function automatic logic [63:0] mem_at(input logic [63:0] a);
        return {a[31:0] ^ 32'hC3A5_0F1E, ~a[31:0]};
    endfunction
    assign rd_data_i = mem_at(rd_addr_o);

    stack_push_unit i_stack_push_unit (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [63:0] e_sp, e_data, e_rd;
    logic [7:0]  e_be;
    logic [2:0]  e_fault;

    task automatic model();
        logic [63:0] step, t, nm, om, src;
        step = (op_size_i == 0) ? 64'd2 : (op_size_i == 1) ? 64'd4 : 64'd8;
        t = sp_i - step;
        if (stk_size_i == 0) begin
            e_sp = sp_i; e_sp[15:0] = t[15:0]; nm = {48'd0, t[15:0]}; om = {48'd0, sp_i[15:0]};
        end else if (stk_size_i == 1) begin
            e_sp = sp_i; e_sp[31:0] = t[31:0]; nm = {32'd0, t[31:0]}; om = {32'd0, sp_i[31:0]};
        end else begin
            e_sp = t; nm = t; om = sp_i;
        end
        e_rd = (mem_sp_base_i ? sp_i : src_val_i) + mem_disp_i;
        case (src_kind_i)
            3'd1: src = mem_at(e_rd);
            3'd2: src = (imm_width_i == 0) ? 64'($signed(src_val_i[7:0])) :
                        (imm_width_i == 1) ? 64'($signed(src_val_i[15:0])) :
                                             64'($signed(src_val_i[31:0]));
            3'd3: src = {48'd0, src_val_i[15:0]};
            3'd4: src = sp_i;
            default: src = src_val_i;
        endcase
        e_data = (op_size_i == 0) ? (src & 64'hFFFF) : (op_size_i == 1) ? (src & 64'hFFFF_FFFF) : src;
        e_be = (op_size_i == 0) ? 8'h03 : (op_size_i == 1) ? ((src_kind_i == 3) ? 8'h03 : 8'h0F) : 8'hFF;
        if (lock_i || (src_kind_i == 3 && seg_legacy_i && mode_i == 2)) e_fault = 3'd2;
        else if (nm > stk_limit_i) e_fault = 3'd1;
        else e_fault = 3'd0;
        if (e_fault != 0) e_sp = sp_i;
        if (mode_i == 0 && om == 64'd1) e_fault = 3'd7; // escalation, not used here
    endtask

    task automatic run_push(input string tag);
        int cyc = 1;
        bit got_rd = 1'b0;
        logic [63:0] rd_seen = '0;
        model();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 6) begin
            if (rd_en_o) begin got_rd = 1'b1; rd_seen = rd_addr_o; end
            @(negedge clk);
            cyc++;
        end
        // R11: latency 1 or 2 cycles
        chk(done_o && cyc == ((src_kind_i == 3'd1) ? 2 : 1), {tag, " R11 latency"}, 64'(cyc), 64'((src_kind_i == 3'd1) ? 2 : 1));
        chk(fault_o == e_fault, {tag, " R7/R8/R9 fault"}, 64'(fault_o), 64'(e_fault));
        chk(sp_o == e_sp, {tag, " R1/R2 sp"}, sp_o, e_sp);
        chk(wr_en_o == (e_fault == 0), {tag, " R7 wr_en"}, 64'(wr_en_o), 64'(e_fault == 0));
        if (e_fault == 0) begin
            chk(wr_addr_o == e_sp, {tag, " R1 addr"}, wr_addr_o, e_sp);
            chk(wr_data_o == e_data, {tag, " R3/R4/R5 data"}, wr_data_o, e_data);
            chk(wr_be_o == e_be, {tag, " R4 be"}, 64'(wr_be_o), 64'(e_be));
        end
        if (src_kind_i == 3'd1)
            chk(got_rd && rd_seen == e_rd, {tag, " R6 rd_addr"}, rd_seen, e_rd);
        @(negedge clk);
        chk(!done_o, {tag, " R11 single done"}, 64'(done_o), 64'd0);
    endtask

    task automatic set_req(input logic [63:0] sp, input logic [1:0] stk, input logic [1:0] op,
                           input logic [2:0] kind, input logic [63:0] val);
        sp_i = sp; stk_size_i = stk; op_size_i = op; src_kind_i = kind; src_val_i = val;
        imm_width_i = 2'd0; seg_legacy_i = 1'b0; mem_sp_base_i = 1'b0; mem_disp_i = '0;
        lock_i = 1'b0; mode_i = 2'd1; stk_limit_i = '1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!finished) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!done_o && !wr_en_o && !rd_en_o && !shutdown_o && fault_o == 0, "R12 reset", 64'(done_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && fault_o == 0, "R12 after reset", 64'(fault_o), 64'd0);

        set_req(64'h0000_7000_0000_1000, 2, 2, 0, 64'h1122_3344_5566_7788); run_push("R1 reg64");
        set_req(64'hABCD_0000_1234_0000, 0, 0, 0, 64'h55AA); run_push("R2 wrap16");
        set_req(64'h1234_5678_0000_0002, 1, 2, 0, 64'h9); run_push("R2 wrap32");
        set_req(64'h8000, 2, 2, 2, 64'h80); imm_width_i = 0; run_push("R3 imm8");
        set_req(64'h8000, 2, 1, 2, 64'h8000); imm_width_i = 1; run_push("R3 imm16");
        set_req(64'h8000, 2, 2, 2, 64'h8000_0000); imm_width_i = 2; run_push("R3 imm32");
        set_req(64'h8000, 1, 1, 3, 64'hFFFF_BEEF); run_push("R4 seg32");
        set_req(64'h8000, 2, 2, 3, 64'hFFFF_0023); run_push("R4 seg64");
        set_req(64'h0000_0000_0000_4440, 2, 2, 4, 64'h0); run_push("R5 self");
        set_req(64'h3000, 2, 2, 1, 64'h9999_0000); mem_sp_base_i = 1; mem_disp_i = 64'h10; run_push("R6 mem sp base");
        set_req(64'h3000, 2, 1, 1, 64'h9999_0000); mem_disp_i = 64'h8; run_push("R6 mem reg base");
        set_req(64'h3000, 2, 2, 0, 64'h1); lock_i = 1; run_push("R7 lock");
        set_req(64'h3000, 2, 2, 3, 64'h10); seg_legacy_i = 1; mode_i = 2; run_push("R8 legacy seg 64");
        set_req(64'h3000, 2, 2, 3, 64'h10); seg_legacy_i = 1; mode_i = 1; run_push("R8 legacy seg prot");
        set_req(64'h3000, 2, 2, 3, 64'h10); mode_i = 2; run_push("R8 new seg 64");
        set_req(64'h0100, 0, 0, 0, 64'h7); stk_limit_i = 64'hFE; run_push("R9 on limit");
        set_req(64'h0100, 0, 0, 0, 64'h7); stk_limit_i = 64'hFD; run_push("R9 over limit");
        set_req(64'h0100, 0, 0, 0, 64'h7); stk_limit_i = 64'hFD; lock_i = 1; run_push("R11 lock priority");

        for (int i = 0; i < 400; i++) begin
            sp_i = {$urandom, $urandom}; stk_size_i = 2'($urandom_range(0, 2));
            op_size_i = 2'($urandom_range(0, 2)); src_kind_i = 3'($urandom_range(0, 4));
            src_val_i = {$urandom, $urandom}; imm_width_i = 2'($urandom_range(0, 2));
            seg_legacy_i = 1'($urandom); mem_sp_base_i = 1'($urandom);
            mem_disp_i = 64'($urandom_range(0, 255)); lock_i = ($urandom_range(0, 15) == 0);
            mode_i = 2'($urandom_range(0, 2));
            stk_limit_i = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : '1;
            if (mode_i == 0 && sp_i[15:0] == 16'd1) sp_i[1] = 1'b1;
            run_push("random");
        end

        // R10 escalation chain
        set_req(64'h0000_0000_0000_0001, 0, 0, 0, 64'h5); mode_i = 0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        chk(fault_o == 3'd1 && !done_o && !wr_en_o, "R10 first stack fault", 64'(fault_o), 64'd1);
        @(negedge clk);
        chk(fault_o == 3'd3 && !done_o, "R10 double fault", 64'(fault_o), 64'd3);
        @(negedge clk);
        chk(fault_o == 3'd4 && done_o && !wr_en_o, "R10 shutdown report", 64'(fault_o), 64'd4);
        @(negedge clk);
        chk(shutdown_o, "R10 shutdown set", 64'(shutdown_o), 64'd1);
        set_req(64'h8000, 2, 2, 0, 64'h1);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(shutdown_o && !done_o && !wr_en_o && !rd_en_o, "R10 halted ignores start", 64'(done_o), 64'd0);
            @(negedge clk);
        end
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk(!shutdown_o, "R12 reset clears shutdown", 64'(shutdown_o), 64'd0);
        set_req(64'h8000, 2, 2, 0, 64'h77); run_push("R1 after recovery");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule